// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block runs the register sequence that moves a CPU clock domain from one frequency to another. Each frequency change takes two requests. A preparation request goes before the domain PLL is reprogrammed. A completion request goes after it. For each request the block takes three rates in Hz: the old rate, the new rate and the rate of the alternate clock source. It looks the new rate up in a small configuration table and then performs a fixed series of reads, writes and status polls on a clock-control register bank. It reaches the bank through a simple register master port.

During preparation the domain is parked on the alternate source. If that source is faster than the old rate, or if the frequency is dropping, a safe pre-divider is loaded first. This keeps the domain clock at or below the lower of the two rates. During completion the domain goes back to the main source and the pre-divider is released. Every status poll has a cycle budget. When a poll runs out, an error bit is set and the sequence moves on to its next step.

Top module: `cpuclk_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `bus_rd` and `bus_wr` are all 0, and they stay 0 until `start` is seen.
- R2: Table entry i (i < ENTRIES) holds the rate STEP_KHZ*(ENTRIES-i) kHz, a first-divider word with bits 18:16 = (i+1) mod 8 and bits 10:8 = i mod 8, and a second-divider word with bits 6:4 = i mod 8 and bits 2:0 = (i+2) mod 8. The lowest i whose rate times 1000 equals the new rate is used. A preparation request searches the table, and so does a completion request when DBG_DIV=1. A search that finds no entry sets `err` bit 0, makes no bus write, and ends with `done`.
- R3: During preparation a safe divider is used when alt > old or old > new. Its value is ceil(alt / min(old,new)) - 1, saturated to 7. It is written by read-modify-write into bits 2:0 of the first divider register (0x300). When DBG_DIV=1, bits 18:16 are forced to 7 in the same write. The block then polls 0x400 until the bits under that write's mask read zero.
- R4: During preparation the block reads the source register (0x000), writes it back with bit 16 set, and then polls 0x200 until bits 18:16 read 2.
- R5: Once the alternate source is selected, the block writes the table's first-divider word to 0x300. When the safe divider is used, the safe value is ORed into bits 2:0 (and 7 into bits 18:16 when DBG_DIV=1). It then polls 0x400 until the whole word reads zero.
- R6: When HAS_DIV1=1, the next write goes to 0x304. If bit 20 of the source value read in R4 was 0, the write carries the table's second-divider word. If it was 1, the block reads 0x304 and writes back only bits 6:4 and 2:0 of that value. It then polls 0x404 until the whole word reads zero.
- R7: During completion the block reads 0x000 and writes it back with bit 16 clear, then polls 0x200 until bits 18:16 read 1. Next it does a read-modify-write of 0x300 that sets bits 2:0 to 0 and, when DBG_DIV=1, loads bits 18:16 from the table. It then polls 0x400 on that mask.
- R8: A poll that is not satisfied within TIMEOUT_CYC cycles sets `err` bit 1 (divider poll) or bit 2 (source-status poll), and the sequence continues with its next step. The write sequence is unchanged by a timeout.
- R9: `start` is taken only when the block is idle, with `phase` 0 for preparation and 1 for completion. Taking a request clears `err`. `busy` is 1 from the cycle after acceptance through the `done` cycle. `done` is 1 for exactly one cycle, after which the block is idle. `err` holds its value until the next request is taken.
- R10: `bus_rd` and `bus_wr` are never 1 in the same cycle. Read data is taken from `bus_rdata` in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when idle |
| phase | input | 1 | 0 = preparation, 1 = completion |
| old_rate | input | RATE_W | Current rate in Hz |
| new_rate | input | RATE_W | Target rate in Hz |
| alt_rate | input | RATE_W | Alternate source rate in Hz |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Sticky errors: bit 0 table miss, bit 1 divider timeout, bit 2 source timeout |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | 12 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench builds the block with ENTRIES=4, STEP_KHZ=100000, TIMEOUT_CYC=40, HAS_DIV1=1 and DBG_DIV=1. With these values the trace-field forcing, the second-divider paths and a table miss (250 MHz) can all be reached. The short timeout lets a stuck source-status field and a stuck divider-busy field both expire within a few hundred cycles. An alternate rate of 2 GHz against 100 MHz drives the safe divider into saturation, and a bench-side bank model with multi-cycle busy bits checks every write, including its address, data and order.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;

  localparam logic [11:0] A_SRC    = 12'h000;
  localparam logic [11:0] A_MSTAT  = 12'h200;
  localparam logic [11:0] A_DIV0   = 12'h300;
  localparam logic [11:0] A_DIV1   = 12'h304;
  localparam logic [11:0] A_DSTAT0 = 12'h400;
  localparam logic [11:0] A_DSTAT1 = 12'h404;

  localparam int SEL_BIT = 16;
  localparam int HPM_BIT = 20;
  localparam int MUX_LSB = 16;

  localparam logic [31:0] RATIO_MASK = 32'h0000_0007;
  localparam logic [31:0] TRACE_MASK = 32'h0007_0000;
  localparam logic [31:0] KEEP1_MASK = 32'h0000_0077;

  localparam logic [2:0] MUX_ALT  = 3'd2;
  localparam logic [2:0] MUX_MAIN = 3'd1;

  localparam int DIV_LIMIT = 8;
  localparam int ERR_MISS = 0;
  localparam int ERR_DIV  = 1;
  localparam int ERR_MUX  = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_RD_D0S, S_WR_D0S, S_RD_SRC, S_WR_SRC,
    S_WR_D0F, S_RD_D1, S_WR_D1, S_POLL_RD, S_POLL_CK, S_DONE
  } state_t;

  function automatic logic [31:0] tbl_khz(int idx, int entries, int step_khz);
    return (idx < entries) ? 32'(step_khz * (entries - idx)) : 32'd0;
  endfunction

  function automatic logic [31:0] tbl_div0(int idx);
    return {13'd0, 3'(idx + 1), 5'd0, 3'(idx), 8'd0};
  endfunction

  function automatic logic [31:0] tbl_div1(int idx);
    return {25'd0, 3'(idx), 1'b0, 3'(idx + 2)};
  endfunction

endpackage

// File: rtl/cpuclk_seq_lookup.sv
module cpuclk_seq_lookup
  import cpuclk_seq_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int STEP_KHZ = 100000,
  parameter int RATE_W   = 32
) (
  input  logic [RATE_W-1:0] rate,
  output logic              hit,
  output logic [31:0]       div0,
  output logic [31:0]       div1
);

  // Walk the table from the top so that the lowest matching index wins.
  always_comb begin
    hit  = 1'b0;
    div0 = '0;
    div1 = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (64'(tbl_khz(i, ENTRIES, STEP_KHZ)) * 64'd1000 == 64'(rate)) begin
        hit  = 1'b1;
        div0 = tbl_div0(i);
        div1 = tbl_div1(i);
      end
    end
  end

endmodule

// File: rtl/cpuclk_seq_safediv.sv
module cpuclk_seq_safediv
  import cpuclk_seq_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic [RATE_W-1:0] old_r,
  input  logic [RATE_W-1:0] new_r,
  input  logic [RATE_W-1:0] alt_r,
  output logic              need,
  output logic [2:0]        div,
  output logic              sat
);

  localparam int KW = $clog2(DIV_LIMIT) + 1;
  localparam int PW = RATE_W + KW;

  logic [RATE_W-1:0]    lo;
  logic [DIV_LIMIT-1:0] fits;

  assign lo   = (old_r < new_r) ? old_r : new_r;
  assign need = (alt_r > old_r) || (old_r > new_r);

  // fits[k]: alt / (k+1) does not exceed the lower rate.
  for (genvar k = 0; k < DIV_LIMIT; k++) begin : g_cmp
    assign fits[k] = PW'(alt_r) <= PW'(lo) * PW'(k + 1);
  end

  always_comb begin
    div = 3'(DIV_LIMIT - 1);
    sat = 1'b1;
    for (int k = DIV_LIMIT - 1; k >= 0; k--) begin
      if (fits[k]) begin
        div = 3'(k);
        sat = 1'b0;
      end
    end
  end

endmodule

// File: rtl/cpuclk_seq_timer.sv
module cpuclk_seq_timer #(
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == CW'(TIMEOUT_CYC));
  assign cnt_en  = clear || (run && !expired);
  assign cnt_d   = clear ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TIMEOUT_CYC));

  assert_expiry_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);

endmodule

// File: rtl/cpuclk_seq.sv
module cpuclk_seq
  import cpuclk_seq_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int STEP_KHZ    = 100000,
  parameter int TIMEOUT_CYC = 1000000,
  parameter int RATE_W      = 32,
  parameter bit HAS_DIV1    = 1'b1,
  parameter bit DBG_DIV     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              phase,
  input  logic [RATE_W-1:0] old_rate,
  input  logic [RATE_W-1:0] new_rate,
  input  logic [RATE_W-1:0] alt_rate,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [11:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);

  localparam logic [31:0] DBG_FIELD = DBG_DIV ? TRACE_MASK : 32'd0;
  localparam logic [31:0] D0S_MASK  = RATIO_MASK | DBG_FIELD;

  state_t            state_q, state_d, ret_q, ret_d;
  logic              phase_q;
  logic [RATE_W-1:0] old_q, new_q, alt_q;
  logic [31:0]       tbl0_q, tbl1_q;
  logic              need_q, hpm_q;
  logic [2:0]        safe_q;
  logic [11:0]       paddr_q, paddr_d;
  logic [31:0]       pmask_q, pmask_d;
  logic              pmux_q, pmux_d;
  logic [2:0]        pwant_q, pwant_d;
  logic [2:0]        err_q, err_d;
  logic              cap_en, lat_en, hpm_en, poll_en;

  logic              lk_hit, lk_need;
  logic [31:0]       lk_div0, lk_div1;
  logic              sd_need, sd_sat;
  logic [2:0]        sd_div;
  logic              tmr_clear, tmr_exp, poll_ok;
  logic [31:0]       d0s_val, safe_word;

  cpuclk_seq_lookup #(.ENTRIES(ENTRIES), .STEP_KHZ(STEP_KHZ), .RATE_W(RATE_W)) u_lookup (
    .rate(new_q), .hit(lk_hit), .div0(lk_div0), .div1(lk_div1)
  );

  cpuclk_seq_safediv #(.RATE_W(RATE_W)) u_safediv (
    .old_r(old_q), .new_r(new_q), .alt_r(alt_q),
    .need(sd_need), .div(sd_div), .sat(sd_sat)
  );

  assign tmr_clear = !(state_q == S_POLL_RD || state_q == S_POLL_CK);

  cpuclk_seq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(!tmr_clear), .expired(tmr_exp)
  );

  assign lk_need   = !phase_q || DBG_DIV;
  assign safe_word = {29'd0, safe_q} | DBG_FIELD;
  assign d0s_val   = phase_q ? (tbl0_q & DBG_FIELD) : safe_word;
  assign poll_ok   = pmux_q ? (bus_rdata[MUX_LSB +: 3] == pwant_q)
                            : ((bus_rdata & pmask_q) == 32'd0);

  assign busy = (state_q != S_IDLE);
  assign done = (state_q == S_DONE);
  assign err  = err_q;

  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    paddr_d   = paddr_q;
    pmask_d   = pmask_q;
    pmux_d    = pmux_q;
    pwant_d   = pwant_q;
    err_d     = err_q;
    cap_en    = 1'b0;
    lat_en    = 1'b0;
    hpm_en    = 1'b0;
    poll_en   = 1'b0;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = 12'd0;
    bus_wdata = 32'd0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          err_d   = '0;
          state_d = S_LOOK;
        end
      end
      S_LOOK: begin
        if (lk_need && !lk_hit) begin
          err_d[ERR_MISS] = 1'b1;
          state_d         = S_DONE;
        end else begin
          lat_en  = 1'b1;
          state_d = (!phase_q && sd_need) ? S_RD_D0S : S_RD_SRC;
        end
      end
      S_RD_D0S: begin
        bus_rd   = 1'b1;
        bus_addr = A_DIV0;
        state_d  = S_WR_D0S;
      end
      S_WR_D0S: begin
        bus_wr    = 1'b1;
        bus_addr  = A_DIV0;
        bus_wdata = (bus_rdata & ~D0S_MASK) | (d0s_val & D0S_MASK);
        poll_en   = 1'b1;
        paddr_d   = A_DSTAT0;
        pmask_d   = D0S_MASK;
        pmux_d    = 1'b0;
        ret_d     = phase_q ? S_DONE : S_RD_SRC;
        state_d   = S_POLL_RD;
      end
      S_RD_SRC: begin
        bus_rd   = 1'b1;
        bus_addr = A_SRC;
        state_d  = S_WR_SRC;
      end
      S_WR_SRC: begin
        hpm_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = A_SRC;
        bus_wdata = bus_rdata;
        bus_wdata[SEL_BIT] = !phase_q;
        poll_en   = 1'b1;
        paddr_d   = A_MSTAT;
        pmux_d    = 1'b1;
        pwant_d   = phase_q ? MUX_MAIN : MUX_ALT;
        ret_d     = phase_q ? S_RD_D0S : S_WR_D0F;
        state_d   = S_POLL_RD;
      end
      S_WR_D0F: begin
        bus_wr    = 1'b1;
        bus_addr  = A_DIV0;
        bus_wdata = tbl0_q | (need_q ? safe_word : 32'd0);
        poll_en   = 1'b1;
        paddr_d   = A_DSTAT0;
        pmask_d   = '1;
        pmux_d    = 1'b0;
        ret_d     = !HAS_DIV1 ? S_DONE : (hpm_q ? S_RD_D1 : S_WR_D1);
        state_d   = S_POLL_RD;
      end
      S_RD_D1: begin
        bus_rd   = 1'b1;
        bus_addr = A_DIV1;
        state_d  = S_WR_D1;
      end
      S_WR_D1: begin
        bus_wr    = 1'b1;
        bus_addr  = A_DIV1;
        bus_wdata = hpm_q ? (bus_rdata & KEEP1_MASK) : tbl1_q;
        poll_en   = 1'b1;
        paddr_d   = A_DSTAT1;
        pmask_d   = '1;
        pmux_d    = 1'b0;
        ret_d     = S_DONE;
        state_d   = S_POLL_RD;
      end
      S_POLL_RD: begin
        bus_rd   = 1'b1;
        bus_addr = paddr_q;
        state_d  = S_POLL_CK;
      end
      S_POLL_CK: begin
        if (poll_ok) begin
          state_d = ret_q;
        end else if (tmr_exp) begin
          if (pmux_q) err_d[ERR_MUX] = 1'b1;
          else        err_d[ERR_DIV] = 1'b1;
          state_d = ret_q;
        end else begin
          state_d = S_POLL_RD;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ret_q   <= S_IDLE;
      err_q   <= '0;
      phase_q <= 1'b0;
      old_q   <= '0;
      new_q   <= '0;
      alt_q   <= '0;
      tbl0_q  <= '0;
      tbl1_q  <= '0;
      need_q  <= 1'b0;
      safe_q  <= '0;
      hpm_q   <= 1'b0;
      paddr_q <= '0;
      pmask_q <= '0;
      pmux_q  <= 1'b0;
      pwant_q <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (cap_en) begin
        phase_q <= phase;
        old_q   <= old_rate;
        new_q   <= new_rate;
        alt_q   <= alt_rate;
      end
      if (lat_en) begin
        tbl0_q <= lk_div0;
        tbl1_q <= lk_div1;
        need_q <= sd_need && !phase_q;
        safe_q <= sd_div;
      end
      if (hpm_en) hpm_q <= bus_rdata[HPM_BIT];
      if (poll_en) begin
        ret_q   <= ret_d;
        paddr_q <= paddr_d;
        pmask_q <= pmask_d;
        pmux_q  <= pmux_d;
        pwant_q <= pwant_d;
      end
    end
  end

  assert_no_rdwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_miss_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOOK && lk_need && !lk_hit) |=> (done && !bus_wr));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == S_IDLE && start) |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_sat_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_sat |-> (sd_div == 3'd7));

endmodule

// File: tb/cpuclk_seq_test.sv
module cpuclk_seq_test;

  localparam int N    = 4;
  localparam int STEP = 100000;
  localparam int TMO  = 40;

  logic        clk, rst_n, start, phase;
  logic [31:0] old_rate, new_rate, alt_rate;
  logic        busy, done;
  logic [2:0]  err;
  logic        bus_rd, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  cpuclk_seq #(.ENTRIES(N), .STEP_KHZ(STEP), .TIMEOUT_CYC(TMO),
               .RATE_W(32), .HAS_DIV1(1'b1), .DBG_DIV(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
    .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
    .busy(busy), .done(done), .err(err),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- register bank model ----------------
  logic [31:0] bk_src, bk_div0, bk_div1, pend0, pend1;
  int          bc0, bc1, mc;
  logic        stuck_mux, stuck_div, hpm_req, hpm_val;
  logic [11:0] wl_a [0:127];
  logic [31:0] wl_d [0:127];
  int          wcnt;
  logic [2:0]  mfield;

  assign mfield = (stuck_mux || mc != 0) ? 3'd4 : (bk_src[16] ? 3'd2 : 3'd1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_src <= 32'd0; bk_div0 <= 32'h0001_0103; bk_div1 <= 32'h0000_0555;
      pend0 <= 0; pend1 <= 0; bc0 <= 0; bc1 <= 0; mc <= 0; wcnt <= 0;
      bus_rdata <= 32'd0;
    end else begin
      if (bc0 != 0) bc0 <= bc0 - 1;
      if (bc1 != 0) bc1 <= bc1 - 1;
      if (mc != 0)  mc  <= mc - 1;
      if (hpm_req) bk_src[20] <= hpm_val;
      if (bus_rd) begin
        case (bus_addr)
          12'h000: bus_rdata <= bk_src;
          12'h200: bus_rdata <= {13'd0, mfield, 16'd0};
          12'h300: bus_rdata <= bk_div0;
          12'h304: bus_rdata <= bk_div1;
          12'h400: bus_rdata <= stuck_div ? 32'hFFFF_FFFF : (bc0 != 0 ? pend0 : 32'd0);
          12'h404: bus_rdata <= stuck_div ? 32'hFFFF_FFFF : (bc1 != 0 ? pend1 : 32'd0);
          default: bus_rdata <= 32'hDEAD_BEEF;
        endcase
      end
      if (bus_wr) begin
        wl_a[wcnt[6:0]] <= bus_addr;
        wl_d[wcnt[6:0]] <= bus_wdata;
        wcnt <= wcnt + 1;
        case (bus_addr)
          12'h000: begin bk_src <= bus_wdata; mc <= 4; end
          12'h300: begin pend0 <= bk_div0 ^ bus_wdata; bk_div0 <= bus_wdata; bc0 <= 3; end
          12'h304: begin pend1 <= bk_div1 ^ bus_wdata; bk_div1 <= bus_wdata; bc1 <= 3; end
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking helpers ----------------
  int n_chk, n_fail;
  logic [11:0] ex_a [0:7];
  logic [31:0] ex_d [0:7];
  int ex_n;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int idx_of(logic [31:0] r);
    for (int i = 0; i < N; i++)
      if (64'(STEP * (N - i)) * 64'd1000 == 64'(r)) return i;
    return -1;
  endfunction

  function automatic logic [31:0] t0(int i);
    return (32'((i + 1) % 8) << 16) | (32'(i % 8) << 8);
  endfunction

  function automatic logic [31:0] t1(int i);
    return (32'(i % 8) << 4) | 32'((i + 2) % 8);
  endfunction

  task automatic push(logic [11:0] a, logic [31:0] d);
    ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
  endtask

  task automatic build_pre(logic [31:0] o, logic [31:0] n, logic [31:0] a);
    int i; logic need; logic [63:0] lo, s; logic [31:0] d0;
    i = idx_of(n); ex_n = 0; d0 = bk_div0;
    if (i < 0) return;
    need = (a > o) || (o > n);
    lo = (o < n) ? 64'(o) : 64'(n);
    s = (64'(a) + lo - 1) / lo - 1;
    if (s > 7) s = 7;
    if (need) push(12'h300, (d0 & ~32'h0007_0007) | 32'h0007_0000 | 32'(s));
    push(12'h000, bk_src | 32'h0001_0000);
    push(12'h300, t0(i) | (need ? (32'h0007_0000 | 32'(s)) : 32'd0));
    push(12'h304, bk_src[20] ? (bk_div1 & 32'h77) : t1(i));
  endtask

  task automatic build_post(logic [31:0] n);
    int i; logic [31:0] d0;
    i = idx_of(n); ex_n = 0; d0 = bk_div0;
    if (i < 0) return;
    push(12'h000, bk_src & ~32'h0001_0000);
    push(12'h300, (d0 & ~32'h0007_0007) | (t0(i) & 32'h0007_0000));
  endtask

  // Drives one request, waits for done, checks writes and the error code.
  task automatic run_req(string req, logic ph, logic [31:0] o, logic [31:0] n,
                         logic [31:0] a, logic [2:0] exp_err, logic poke);
    int base, waited;
    if (ph) build_post(n); else build_pre(o, n, a);
    @(negedge clk);
    base = wcnt;
    phase = ph; old_rate = o; new_rate = n; alt_rate = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R9 busy after accept"}, 64'(busy), 64'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      phase = ~ph; new_rate = 32'd100_000_000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL %s watchdog: actual no done expected done", req);
      return;
    end
    chk({req, " err"}, 64'(err), 64'(exp_err));
    chk({req, " write count"}, 64'(wcnt - base), 64'(ex_n));
    for (int k = 0; k < ex_n; k++)
      chk($sformatf("%s write %0d", req, k),
          {20'd0, wl_a[(base + k) % 128], wl_d[(base + k) % 128]},
          {20'd0, ex_a[k], ex_d[k]});
    @(negedge clk);
    chk({req, " R9 done one cycle"}, {62'd0, done, busy}, 64'd0);
    chk({req, " R9 err held"}, 64'(err), 64'(exp_err));
  endtask

  task automatic t_reset;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R1 reset outputs", {58'd0, busy, done, err, bus_rd, bus_wr}, 64'd0);
    end
  endtask

  task automatic t_pre_down;   // R3 R4 R5 R6: safe divider 2, trace forced
    run_req("R3 R5 pre down", 1'b0, 400_000_000, 200_000_000, 500_000_000, 3'b000, 1'b0);
  endtask

  task automatic t_post;       // R7
    run_req("R7 post", 1'b1, 400_000_000, 200_000_000, 500_000_000, 3'b000, 1'b0);
  endtask

  task automatic t_pre_up;     // R4 R5 R6: no safe divider
    run_req("R4 R6 pre up", 1'b0, 200_000_000, 400_000_000, 100_000_000, 3'b000, 1'b0);
  endtask

  task automatic t_hpm;        // R6: keep bits 6:4 and 2:0 of the second divider
    @(negedge clk); hpm_req = 1'b1; hpm_val = 1'b1;
    @(negedge clk); hpm_req = 1'b0;
    run_req("R6 keep div1", 1'b0, 100_000_000, 300_000_000, 100_000_000, 3'b000, 1'b0);
    @(negedge clk); hpm_req = 1'b1; hpm_val = 1'b0;
    @(negedge clk); hpm_req = 1'b0;
  endtask

  task automatic t_miss;       // R2
    run_req("R2 table miss", 1'b0, 400_000_000, 250_000_000, 100_000_000, 3'b001, 1'b0);
    run_req("R2 post miss", 1'b1, 400_000_000, 250_000_000, 100_000_000, 3'b001, 1'b0);
  endtask

  task automatic t_sat;        // R3: ceil(2000/100)-1 = 19, saturates to 7
    run_req("R3 saturate", 1'b0, 200_000_000, 100_000_000, 2_000_000_000, 3'b000, 1'b0);
  endtask

  task automatic t_mux_tmo;    // R8
    stuck_mux = 1'b1;
    run_req("R8 mux timeout", 1'b0, 200_000_000, 300_000_000, 100_000_000, 3'b100, 1'b0);
    stuck_mux = 1'b0;
  endtask

  task automatic t_div_tmo;    // R8
    stuck_div = 1'b1;
    run_req("R8 div timeout", 1'b0, 200_000_000, 300_000_000, 100_000_000, 3'b010, 1'b0);
    stuck_div = 1'b0;
  endtask

  task automatic t_ignore;     // R9 R10: start while busy is ignored
    int base;
    run_req("R9 start ignored", 1'b0, 100_000_000, 400_000_000, 100_000_000, 3'b000, 1'b1);
    base = wcnt;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R9 stays idle", {62'd0, busy, bus_rd | bus_wr}, 64'd0);
    end
    chk("R10 no extra writes", 64'(wcnt - base), 64'd0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; phase = 1'b0;
    old_rate = 0; new_rate = 0; alt_rate = 0;
    stuck_mux = 1'b0; stuck_div = 1'b0; hpm_req = 1'b0; hpm_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pre_down();
    t_post();
    t_pre_up();
    t_post();
    t_hpm();
    t_miss();
    t_sat();
    t_mux_tmo();
    t_div_tmo();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule